// File: doc/BRIEF.md
# Sticky Event Latch Bank

This block holds a small set of sticky flags, one per status source. Each flag catches an assertion of its source, however short, provided it lasts long enough to be sampled. A front panel power switch press is the typical case. The flag then holds the event until a polling controller collects it. The controller may leave long gaps between polls, and an event that comes and goes inside such a gap is still reported on the next poll.

The controller reads the flags through a minimal read port made of an address, a read strobe and a read data word. A read of the flag register collects every flag and clears it. A flag is cleared only if its source has already gone away at that moment. An event that is still in progress therefore survives the read and is reported again. A single interrupt line is raised for as long as any flag is set. Because it is a level, a source that reasserts close to a read cannot cause an interrupt to be missed.

Each source passes through a two-stage synchronizer before it reaches its flag. Source 0 is wired to the front panel power switch by convention. The reset is asynchronous and active-low, and it is expected to be released synchronously by the reset network outside the block.

Top module: `evtlatch_bank`

## Requirements
- R1: While `rst_n` is low, every flag is clear and `irq` is low; after reset a read of address 0 returns zero.
- R2: A source input sampled high at rising edge k sets its flag at rising edge k+2 (two synchronizer stages, then the flag).
- R3: A set flag stays set after its source returns low, for any number of cycles, until a clearing read.
- R4: A read (`rd_en` high) of address 0 returns flag i in `rd_data` bit i for i = 0..3, and bits 7:4 read zero; the data is valid combinationally in the cycle of the strobe. Flag 0 belongs to the power switch source.
- R5: A read of address 0 clears, at the rising edge that ends the strobe cycle, every flag whose synchronized source is low at that edge.
- R6: A flag whose synchronized source is high at the edge of a clearing read is set after that edge, including when the source reaches the flag in that same edge.
- R7: A read strobe at any address other than 0 returns zero and changes no flag; with `rd_en` low, `rd_data` is zero.
- R8: `irq` is high in exactly those cycles in which at least one flag is set.
- R9: The flags are independent: a source, a set or a clear on one flag never changes another flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 4 | Raw, asynchronous event sources; bit 0 is the power switch |
| rd_en | input | 1 | Read strobe, one read per cycle it is high |
| rd_addr | input | 2 | Read address; only address 0 is populated |
| rd_data | output | 8 | Read data, flags in bits 3:0 |
| irq | output | 1 | Level interrupt, high while any flag is set |

## Verification
A source change is due in its flag, and so in `irq`, two rising edges after the edge that first samples it. Read data is due in the same cycle as the strobe. A clear is due after the edge that closes the strobe cycle. The bench drives inputs on the falling edge and checks `rd_data` one nanosecond later. It then advances a reference model of the two synchronizer stages and the flags at the rising edge, and checks `irq` against that model before it drives the next inputs. The directed cases place a source pulse so that it reaches its flag exactly at the edge of a clearing read, and they hold a source high across several reads.

// File: rtl/evtlatch_pkg.sv
`timescale 1ns/1ps
package evtlatch_pkg;
  localparam int unsigned EVT_COUNT_DEF  = 4;
  localparam int unsigned DATA_W_DEF     = 8;
  localparam int unsigned ADDR_W_DEF     = 2;
  localparam int unsigned SYNC_DEPTH_DEF = 2;
  localparam int unsigned FLAG_ADDR      = 0;
endpackage

// File: rtl/evtlatch_sync.sv
`timescale 1ns/1ps
module evtlatch_sync #(
  parameter int unsigned WIDTH = 4,
  parameter int unsigned DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [DEPTH];
  logic [WIDTH-1:0] stage_d [DEPTH];

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_d[g] = async_i;
      end else begin : g_next
        always_comb stage_d[g] = stage_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign sync_o = stage_q[DEPTH-1];
endmodule

// File: rtl/evtlatch_cell.sv
`timescale 1ns/1ps
module evtlatch_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  // A live event always wins over a clear request.
  always_comb begin
    flag_en = evt_i | clr_i;
    flag_d  = evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/evtlatch_rdport.sv
`timescale 1ns/1ps
module evtlatch_rdport #(
  parameter int unsigned NFLAG  = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned BASE   = 0
) (
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NFLAG-1:0]  flags_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned PAD_W = DATA_W - NFLAG;

  always_comb begin
    hit_o   = rd_en && (rd_addr == ADDR_W'(BASE));
    rd_data = '0;
    if (hit_o) rd_data = {{PAD_W{1'b0}}, flags_i};
  end
endmodule

// File: rtl/evtlatch_bank.sv
`timescale 1ns/1ps
module evtlatch_bank
  import evtlatch_pkg::*;
#(
  parameter int unsigned NUM_SRC    = EVT_COUNT_DEF,
  parameter int unsigned DATA_W     = DATA_W_DEF,
  parameter int unsigned ADDR_W     = ADDR_W_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               irq
);
  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] latch_q;
  logic [NUM_SRC-1:0] clr_req;
  logic               rd_hit;

  evtlatch_sync #(.WIDTH(NUM_SRC), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(src_i), .sync_o(src_sync)
  );

  evtlatch_rdport #(
    .NFLAG(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(FLAG_ADDR)
  ) u_rd (
    .rd_en(rd_en), .rd_addr(rd_addr), .flags_i(latch_q),
    .hit_o(rd_hit), .rd_data(rd_data)
  );

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_flag
      always_comb clr_req[i] = rd_hit;
      evtlatch_cell u_cell (
        .clk(clk), .rst_n(rst_n), .evt_i(src_sync[i]),
        .clr_i(clr_req[i]), .flag_o(latch_q[i])
      );
    end
  endgenerate

  assign irq = |latch_q;
endmodule

// File: rtl/evtlatch_bank_chk.sv
`timescale 1ns/1ps
module evtlatch_bank_chk #(
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ADDR_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] src_sync,
  input logic [NUM_SRC-1:0] latch_q,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic [DATA_W-1:0]  rd_data,
  input logic               irq
);
  logic flag_read;
  assign flag_read = rd_en && (rd_addr == '0);

  // R8: a read of the flag word shows data exactly when irq is up
  a_r8_irq_vs_read: assert property (@(posedge clk) disable iff (!rst_n)
    flag_read |-> (irq == (rd_data != '0)));

  // R4: unused upper bits read zero
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:NUM_SRC] == '0);

  // R7: reads elsewhere or no strobe return zero
  a_r7_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_read |-> (rd_data == '0));

  genvar i;
  generate
    for (i = 0; i < NUM_SRC; i++) begin : g_bit
      // R2: a synchronized event sets its flag at the next edge
      a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
        src_sync[i] |=> latch_q[i]);
      // R3: no clearing read, the flag holds
      a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q[i] && !flag_read) |=> latch_q[i]);
      // R5: clearing read with idle source empties the flag
      a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_read && !src_sync[i]) |=> !latch_q[i]);
      // R6: live event survives the read
      a_r6_busy_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_read && src_sync[i]) |=> latch_q[i]);
    end
  endgenerate
endmodule

bind evtlatch_bank evtlatch_bank_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_sync(src_sync), .latch_q(latch_q),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
);

// File: tb/evtlatch_bank_bench.sv
`timescale 1ns/1ps
module evtlatch_bank_bench;
  logic       clk;
  logic       rst_n;
  logic [3:0] src;
  logic       rd_en;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       irq;

  int n_cmp;
  int n_bad;
  logic [3:0] m_s1, m_s2, m_lat;

  evtlatch_bank u_evtlatch_bank (
    .clk(clk), .rst_n(rst_n), .src_i(src), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] exp_read(input logic rd, input logic [1:0] a,
                                          input logic [3:0] lat);
    return (rd && a == 2'd0) ? {4'b0000, lat} : 8'h00;
  endfunction

  function automatic logic [3:0] exp_next(input logic [3:0] s2, input logic [3:0] lat,
                                          input logic hit);
    return s2 | (lat & ~{4{hit}});
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic [3:0] s, input logic rd, input logic [1:0] a,
                     input string req);
    logic hit;
    @(negedge clk);
    chk("R8", {31'b0, irq}, {31'b0, |m_lat});
    src = s; rd_en = rd; rd_addr = a;
    #1;
    chk(req, {24'b0, rd_data}, {24'b0, exp_read(rd, a, m_lat)});
    @(posedge clk);
    hit   = rd && (a == 2'd0);
    m_lat = exp_next(m_s2, m_lat, hit);
    m_s2  = m_s1;
    m_s1  = s;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; src = '0; rd_en = 1'b0; rd_addr = '0;
    m_s1 = '0; m_s2 = '0; m_lat = '0;
    #1;
    chk("R1", {31'b0, irq}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; src = '0; rd_en = 1'b0; rd_addr = '0;
    m_s1 = '0; m_s2 = '0; m_lat = '0;
    do_reset();
    cyc(4'h0, 1'b1, 2'd0, "R1");

    // R2 / R4: single-cycle press on the power switch source
    cyc(4'h1, 1'b0, 2'd0, "R2");
    repeat (3) cyc(4'h0, 1'b0, 2'd0, "R2");
    // R3: long gap before the poll
    repeat (12) cyc(4'h0, 1'b0, 2'd0, "R3");
    cyc(4'h0, 1'b1, 2'd0, "R4");
    cyc(4'h0, 1'b1, 2'd0, "R5");

    // R6: source held across several reads, then R5 after release
    repeat (4) cyc(4'h4, 1'b0, 2'd0, "R6");
    cyc(4'h4, 1'b1, 2'd0, "R6");
    cyc(4'h4, 1'b1, 2'd0, "R6");
    repeat (3) cyc(4'h0, 1'b0, 2'd0, "R5");
    cyc(4'h0, 1'b1, 2'd0, "R5");
    cyc(4'h0, 1'b1, 2'd0, "R5");

    // R7: read at other addresses and no strobe leave the flag alone
    cyc(4'h2, 1'b0, 2'd0, "R7");
    repeat (3) cyc(4'h0, 1'b0, 2'd0, "R7");
    cyc(4'h0, 1'b1, 2'd2, "R7");
    cyc(4'h0, 1'b1, 2'd1, "R7");
    cyc(4'h0, 1'b1, 2'd3, "R7");
    cyc(4'h0, 1'b0, 2'd0, "R7");
    cyc(4'h0, 1'b1, 2'd0, "R7");

    // R6: event reaches its flag exactly at the edge of a clearing read
    cyc(4'h8, 1'b0, 2'd0, "R6");
    cyc(4'h0, 1'b0, 2'd0, "R6");
    cyc(4'h0, 1'b1, 2'd0, "R6");
    cyc(4'h0, 1'b1, 2'd0, "R6");
    cyc(4'h0, 1'b1, 2'd0, "R6");

    // R9: staggered events on all sources
    cyc(4'h1, 1'b0, 2'd0, "R9");
    cyc(4'h2, 1'b0, 2'd0, "R9");
    cyc(4'h4, 1'b1, 2'd0, "R9");
    cyc(4'h8, 1'b0, 2'd0, "R9");
    repeat (3) cyc(4'h0, 1'b0, 2'd0, "R9");
    cyc(4'h0, 1'b1, 2'd0, "R9");
    cyc(4'h0, 1'b1, 2'd0, "R9");

    // R1: reset in the middle of activity
    repeat (3) cyc(4'hF, 1'b0, 2'd0, "R9");
    do_reset();
    cyc(4'h0, 1'b1, 2'd0, "R1");

    // R9: constrained random traffic, fixed seed
    void'($urandom(32'h5EED1234));
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] s;
      logic       rd;
      logic [1:0] a;
      s  = 4'($urandom) & 4'($urandom) & 4'($urandom);
      rd = ($urandom % 4) == 0;
      a  = (($urandom % 5) == 0) ? 2'($urandom) : 2'd0;
      cyc(s, rd, a, "R9");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule